// File: doc/BRIEF.md
# Host Data Port with FIFO Access-Error Flag

This block is the data register that a host sees in front of a controller with one transmit queue and one receive queue. A host write strobe pushes a word into the transmit FIFO. A host read strobe pops the oldest word from the receive FIFO and latches it into a held read-data register. The serial side of the controller, which is not part of this block, drains the transmit FIFO and fills the receive FIFO through its own pop and push strobes.

Two host accesses are illegal: writing while the transmit FIFO is full, and reading while the receive FIFO is empty. An illegal access changes no FIFO pointer. A write on full is dropped. A read on empty leaves the held read data at the value of the last good read. Either case raises a sticky access-error flag. The flag is a level output meant for an interrupt status register, and the host clears it by writing 1 to it.

The flag is a two-state machine. In FLAG_CLEAR, an illegal access takes the transition RAISE to FLAG_RAISED. In FLAG_RAISED, a clear write with data 1 and no illegal access in the same cycle takes the transition ACK back to FLAG_CLEAR. Every other input leaves the state where it is, which is the HOLD transition.

Top module: `hdp_data_port`

## Requirements
- R1: A host write while the transmit FIFO is not full stores `host_wdata`. Words leave through `tx_data` in the order they were written. `tx_data` shows the oldest stored word whenever `tx_empty` is 0.
- R2: A host write while `tx_full` is 1 is discarded. The stored words, their order and `tx_full` are unchanged.
- R3: A host read while the receive FIFO is not empty pops the oldest word. That word appears on `host_rdata` from the next clock edge and stays there until the next good read.
- R4: A host read while `rx_empty` is 1 leaves `host_rdata` at the value from the previous good read, which is 0 if no good read has happened since reset.
- R5: An illegal access leaves both FIFOs' read and write pointers unchanged. The `full`/`empty` outputs and later data show no extra or missing word.
- R6: A write on full or a read on empty sets `access_err` to 1 from the next clock edge.
- R7: `access_err` clears only on a cycle with `err_wr`=1 and `err_wdata`=1. A clear write with `err_wdata`=0 has no effect. If a clear write and an illegal access fall in the same cycle, the flag stays set.
- R8: After reset, `access_err` is 0, `host_rdata` is 0, `tx_empty` and `rx_empty` are 1, and `tx_full` and `rx_full` are 0.
- R9: A legal host read and a legal host write in the same cycle both take effect.
- R10: A serial-side push while `rx_full` is 1, or a serial-side pop while `tx_empty` is 1, is ignored. It does not raise `access_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe to the data register |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe from the data register |
| host_rdata | output | DATA_W | Held read data from the last good read |
| err_wr | input | 1 | Host write strobe to the error flag |
| err_wdata | input | 1 | Data bit for the error flag write (1 clears) |
| access_err | output | 1 | Sticky access-error flag |
| tx_pop | input | 1 | Serial side takes one word from the transmit FIFO |
| tx_data | output | DATA_W | Oldest word in the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_push | input | 1 | Serial side stores one word in the receive FIFO |
| rx_data | input | DATA_W | Word from the serial side |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
The in-line assertions check the following on every cycle:
- A full FIFO stays full, and an empty FIFO stays empty, across a refused access.
- The flag rises one cycle after any illegal access.
- The flag survives any cycle that lacks a write-1 clear.
- The held read data does not move on a read on empty, or on a cycle with no read.

Some behaviour only the bench scenarios can show: the order and values of the words after refused accesses, the result of simultaneous read and write, the 0 returned on an early empty read, and the set-over-clear priority. The bench shows these by comparing every output against a queue model over a fixed vector table, a random phase and directed reset.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic bad;
    } access_t;

endpackage

// File: rtl/hdp_fifo.sv
module hdp_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;

    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              do_push;
    logic              do_pop;

    always_comb begin
        empty   = (wr_ptr == rd_ptr);
        full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    assign head_data = mem[rd_ptr[AW-1:0]];

    // R5, R10: a refused push leaves the queue full
    a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);

    // R5, R10: a refused pop leaves the queue empty
    a_r10_empty_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

    a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: rtl/hdp_access_check.sv
module hdp_access_check
    import hdp_pkg::*;
(
    input  logic    host_wr,
    input  logic    host_rd,
    input  logic    tx_full,
    input  logic    rx_empty,
    output access_t tx_acc,
    output access_t rx_acc,
    output logic    bad_access
);
    always_comb begin
        tx_acc.push = host_wr && !tx_full;
        tx_acc.pop  = 1'b0;
        tx_acc.bad  = host_wr && tx_full;
        rx_acc.push = 1'b0;
        rx_acc.pop  = host_rd && !rx_empty;
        rx_acc.bad  = host_rd && rx_empty;
        bad_access  = tx_acc.bad || rx_acc.bad;
    end
endmodule

// File: rtl/hdp_err_flag.sv
module hdp_err_flag
    import hdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad_access,
    input  logic clr_wr,
    input  logic clr_bit,
    output logic flag
);
    flag_state_t state_q;
    flag_state_t state_d;
    logic        ack;

    assign ack = clr_wr && clr_bit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (bad_access) state_d = FLAG_RAISED;            // RAISE
            FLAG_RAISED: if (ack && !bad_access) state_d = FLAG_CLEAR;     // ACK
            default:     state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_RAISED: flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end

    a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> flag);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> flag);

    a_r7_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack && !bad_access) |=> !flag);

endmodule

// File: rtl/hdp_data_port.sv
module hdp_data_port
    import hdp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              err_wr,
    input  logic              err_wdata,
    output logic              access_err,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    output logic              tx_full,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_empty
);
    access_t           tx_acc;
    access_t           rx_acc;
    logic              bad_access;
    logic [DATA_W-1:0] rx_head;
    logic [DATA_W-1:0] rdata_q;

    hdp_access_check u_chk (
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .tx_full   (tx_full),
        .rx_empty  (rx_empty),
        .tx_acc    (tx_acc),
        .rx_acc    (rx_acc),
        .bad_access(bad_access)
    );

    hdp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tx_acc.push),
        .push_data(host_wdata),
        .pop      (tx_pop),
        .head_data(tx_data),
        .full     (tx_full),
        .empty    (tx_empty)
    );

    hdp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .push_data(rx_data),
        .pop      (rx_acc.pop),
        .head_data(rx_head),
        .full     (rx_full),
        .empty    (rx_empty)
    );

    hdp_err_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .bad_access(bad_access),
        .clr_wr    (err_wr),
        .clr_bit   (err_wdata),
        .flag      (access_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (rx_acc.pop) rdata_q <= rx_head;
    end

    assign host_rdata = rdata_q;

    a_r4_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rx_empty) |=> $stable(host_rdata));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    a_r10_no_serial_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd && !access_err) |=> !access_err);

endmodule

// File: tb/sim_hdp_data_port.sv
module sim_hdp_data_port;
    localparam int DW    = 8;
    localparam int DEPTH = 8;

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] wd;
        logic          rd;
        logic          rxp;
        logic [DW-1:0] rxd;
        logic          txp;
        logic          ew;
        logic          ewd;
    } step_t;

    localparam int NV = 24;
    localparam step_t VEC [NV] = '{
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // read on empty
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // write 0 to flag
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}, // clear flag
        '{1'b1, 8'hA0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA4, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA6, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hA7, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hEE, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // write on full
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'h5B, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b1, 8'hC1, 1'b1, 1'b1, 8'h5C, 1'b0, 1'b0, 1'b0}, // read and write together
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // read on empty
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}, // clear loses to new error
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rd = 1'b0;
    logic [DW-1:0] host_rdata;
    logic          err_wr = 1'b0;
    logic          err_wdata = 1'b0;
    logic          access_err;
    logic          tx_pop = 1'b0;
    logic [DW-1:0] tx_data;
    logic          tx_empty;
    logic          tx_full;
    logic          rx_push = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_full;
    logic          rx_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int unsigned   txq[$];
    int unsigned   rxq[$];
    logic [DW-1:0] m_rdata;
    logic          m_err;

    always #4 clk = ~clk;

    hdp_data_port #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .err_wr(err_wr),
        .err_wdata(err_wdata), .access_err(access_err), .tx_pop(tx_pop),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty)
    );

    task automatic chk(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R3 host_rdata", host_rdata, m_rdata);
        chk("R6 access_err", access_err, m_err);
        chk("R5 tx_empty", tx_empty, txq.size() == 0);
        chk("R2 tx_full", tx_full, txq.size() == DEPTH);
        chk("R5 rx_empty", rx_empty, rxq.size() == 0);
        chk("R10 rx_full", rx_full, rxq.size() == DEPTH);
        if (txq.size() != 0) chk("R1 tx_data", tx_data, txq[0]);
    endtask

    task automatic model_step(step_t s);
        bit txe;
        bit txf;
        bit rxe;
        bit rxf;
        bit bad;
        txe = txq.size() == 0;
        txf = txq.size() == DEPTH;
        rxe = rxq.size() == 0;
        rxf = rxq.size() == DEPTH;
        bad = (s.wr && txf) || (s.rd && rxe);
        if (s.rd && !rxe) begin
            m_rdata = rxq[0][DW-1:0];
            void'(rxq.pop_front());
        end
        if (s.rxp && !rxf) rxq.push_back(s.rxd);
        if (s.txp && !txe) void'(txq.pop_front());
        if (s.wr && !txf) txq.push_back(s.wd);
        if (bad) m_err = 1'b1;
        else if (s.ew && s.ewd) m_err = 1'b0;
    endtask

    task automatic do_step(step_t s);
        @(negedge clk);
        check_all();
        host_wr    = s.wr;
        host_wdata = s.wd;
        host_rd    = s.rd;
        rx_push    = s.rxp;
        rx_data    = s.rxd;
        tx_pop     = s.txp;
        err_wr     = s.ew;
        err_wdata  = s.ewd;
        model_step(s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        host_wr = 1'b0; host_rd = 1'b0; rx_push = 1'b0; tx_pop = 1'b0; err_wr = 1'b0;
        repeat (2) @(negedge clk);
        txq.delete();
        rxq.delete();
        m_rdata = '0;
        m_err   = 1'b0;
        chk("R8 access_err", access_err, 0);
        chk("R8 host_rdata", host_rdata, 0);
        chk("R8 tx_empty", tx_empty, 1);
        chk("R8 rx_empty", rx_empty, 1);
        chk("R8 tx_full", tx_full, 0);
        chk("R8 rx_full", rx_full, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        step_t s;
        do_reset();
        foreach (VEC[i]) do_step(VEC[i]);
        // R10: overfill RX from the serial side and pop TX until empty
        for (int i = 0; i < DEPTH + 3; i++) begin
            s = '0; s.rxp = 1'b1; s.rxd = DW'(8'h30 + i); s.txp = 1'b1;
            do_step(s);
        end
        // R9 and R4: drain RX with reads, overrunning by two
        for (int i = 0; i < DEPTH + 2; i++) begin
            s = '0; s.rd = 1'b1; s.wr = (i < 4); s.wd = DW'(8'h90 + i);
            do_step(s);
        end
        s = '0; s.ew = 1'b1; s.ewd = 1'b1;
        do_step(s);
        // random mix against the queue model
        for (int i = 0; i < 400; i++) begin
            s.wr  = ($urandom_range(0, 1) == 1);
            s.wd  = DW'($urandom);
            s.rd  = ($urandom_range(0, 2) == 0);
            s.rxp = ($urandom_range(0, 2) != 0);
            s.rxd = DW'($urandom);
            s.txp = ($urandom_range(0, 3) == 0);
            s.ew  = ($urandom_range(0, 5) == 0);
            s.ewd = ($urandom_range(0, 1) == 1);
            do_step(s);
        end
        s = '0;
        do_step(s);
        // R8: reset in the middle of traffic
        do_reset();
        s = '0; s.rd = 1'b1;
        do_step(s);
        s = '0;
        do_step(s);
        @(negedge clk);
        check_all();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule